// File: doc/BRIEF.md
# Cross-Tenant Translation Prefetch Unit

This unit sits beside a device-side translation cache and is consulted on the same request. It has two halves. The first is a small, fully associative buffer of guest-page to host-physical translations that every tenant shares. The second is a tenant predictor that learns which source ID tends to follow which, over a programmable history distance. When the buffer holds the requested translation, the unit answers and the request goes no further. On a miss, the predictor is indexed by the requesting source ID. If it holds a valid guess, the unit issues a prefetch naming the predicted tenant.

The memory side answers a prefetch with the two most recent translations of that tenant. These arrive on a fill port, and the second of the pair is flagged as the last one. Fills are written into the shared buffer. At most one prefetch can be outstanding for each tenant. A prefetch is dropped while its tenant still waits for the closing fill, and also while a previous prefetch has not yet been accepted.

The prefetch issue path is a two-state machine. In `PF_IDLE`, the transition to `PF_ISSUE` is taken on an accepted trigger. In `PF_ISSUE`, the request is driven, and the transition back to `PF_IDLE` is taken when the memory side signals ready.

Top module: `xtenant_pf_unit`

## Requirements
- R1: After reset, hit_valid, miss and pf_req_valid are low, the buffer holds no translation, every predictor entry is invalid, and the history length is 48.
- R2: A request whose source ID and guest page both match a buffer entry gives, in the cycle after it is captured, hit_valid high, miss low and hit_phys equal to the stored physical page.
- R3: A request with no entry matching both source ID and page gives miss high and hit_valid low in the following cycle. In a cycle after no request, both are low.
- R4: A request that hits the buffer never starts a prefetch.
- R5: A missing request whose source ID has a valid predictor entry raises pf_req_valid in the next cycle, with pf_req_sid set to the predicted source ID. Both stay unchanged until pf_req_ready is seen high at a clock edge.
- R6: Every request is appended to a log of source IDs. Once at least N requests have been logged, where N is the history length, the predictor entry of the source ID logged N requests earlier is set valid and pointed at the current source ID. The lookup for the current request reads the table as it was before this update.
- R7: A history-length write takes effect for requests captured after the write edge. A value of 0 is stored as 1, and a value above 64 is stored as 64.
- R8: A fill whose source ID and page already sit in the buffer overwrites that entry. Otherwise, the fill takes the lowest-numbered empty entry. When no entry is empty, the victim is chosen by a round-robin pointer that starts at entry 0 and advances by one, wrapping, on each such replacement.
- R9: A trigger is dropped if its predicted source ID already has a prefetch outstanding, or if the issue machine is in `PF_ISSUE`.
- R10: A fill with fill_last high releases its source ID, so a later miss predicting that ID can issue again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_sid | input | SID_W | Requesting source ID |
| req_page | input | PAGE_W | Guest page number of the request |
| hist_len_we | input | 1 | Write strobe for the history length |
| hist_len_din | input | LEN_W | New history length (clamped to 1..HIST_MAX) |
| fill_valid | input | 1 | Returned translation present |
| fill_sid | input | SID_W | Source ID of the returned translation |
| fill_page | input | PAGE_W | Guest page of the returned translation |
| fill_phys | input | PHYS_W | Host physical page of the returned translation |
| fill_last | input | 1 | Final translation of a prefetch |
| hit_valid | output | 1 | Buffer hit result |
| hit_phys | output | PHYS_W | Translation returned on a hit |
| miss | output | 1 | Buffer miss result |
| pf_req_valid | output | 1 | Prefetch request pending |
| pf_req_sid | output | SID_W | Predicted source ID to prefetch |
| pf_req_ready | input | 1 | Memory side accepts the prefetch |

## Verification
Every lookup result (hit_valid, miss, hit_phys) and the rise of pf_req_valid is due one cycle after the edge that captures the request. A fill changes the buffer at its capture edge, so a request captured at the next edge already sees it. The bench drives each input at a falling edge and reads the outputs at the next falling edge, halfway through the cycle in which they are due. It then inserts one idle cycle, so that an accepted prefetch has returned the machine to `PF_IDLE` before the next request, except in the stretch where pf_req_ready is held low on purpose. A bench model of the buffer, the log, the table and the outstanding set supplies the expected value of every output on every request.

// File: rtl/xtp_pkg.sv
package xtp_pkg;

    typedef enum logic [0:0] {
        PF_IDLE  = 1'b0,
        PF_ISSUE = 1'b1
    } pf_state_e;

endpackage

// File: rtl/xtp_pbuf.sv
// Shared, fully associative translation buffer with in-place update,
// empty-first placement and round-robin replacement.
module xtp_pbuf #(
    parameter int SID_W   = 4,
    parameter int PAGE_W  = 20,
    parameter int PHYS_W  = 24,
    parameter int ENTRIES = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SID_W-1:0]  lk_sid,
    input  logic [PAGE_W-1:0] lk_page,
    output logic              lk_hit,
    output logic [PHYS_W-1:0] lk_phys,
    input  logic              fl_valid,
    input  logic [SID_W-1:0]  fl_sid,
    input  logic [PAGE_W-1:0] fl_page,
    input  logic [PHYS_W-1:0] fl_phys
);

    logic [ENTRIES-1:0] ent_v;
    logic [SID_W-1:0]   ent_sid  [ENTRIES];
    logic [PAGE_W-1:0]  ent_page [ENTRIES];
    logic [PHYS_W-1:0]  ent_phys [ENTRIES];
    logic [IDX_W-1:0]   rr_ptr;

    logic [ENTRIES-1:0] lk_match;
    logic [ENTRIES-1:0] fl_match;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign lk_match[g] = ent_v[g] && (ent_sid[g] == lk_sid) && (ent_page[g] == lk_page);
        assign fl_match[g] = ent_v[g] && (ent_sid[g] == fl_sid) && (ent_page[g] == fl_page);
    end

    // Read side: keys are unique, so an OR of masked data is enough.
    always_comb begin
        lk_phys = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (lk_match[i]) lk_phys = lk_phys | ent_phys[i];
        end
        lk_hit = |lk_match;
    end

    // Placement: existing key, else lowest empty, else round-robin victim.
    logic [IDX_W-1:0] slot;
    logic             dup_found;
    logic             empty_found;
    logic             use_rr;

    always_comb begin
        slot        = rr_ptr;
        dup_found   = 1'b0;
        empty_found = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (!dup_found && fl_match[i]) begin
                slot      = IDX_W'(i);
                dup_found = 1'b1;
            end
        end
        if (!dup_found) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (!empty_found && !ent_v[i]) begin
                    slot        = IDX_W'(i);
                    empty_found = 1'b1;
                end
            end
        end
        use_rr = !dup_found && !empty_found;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_v  <= '0;
            rr_ptr <= '0;
        end else if (fl_valid) begin
            ent_v[slot] <= 1'b1;
            if (use_rr) begin
                rr_ptr <= (rr_ptr == IDX_W'(ENTRIES - 1)) ? '0 : rr_ptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (fl_valid) begin
            ent_sid[slot]  <= fl_sid;
            ent_page[slot] <= fl_page;
            ent_phys[slot] <= fl_phys;
        end
    end

endmodule

// File: rtl/xtp_predictor.sv
// Next-tenant predictor: circular source-ID log, direct-mapped table,
// programmable history distance. HIST_MAX must be a power of two.
module xtp_predictor #(
    parameter int SID_W    = 4,
    parameter int HIST_MAX = 64,
    parameter int HIST_DEF = 48,
    localparam int NUM_SID = 1 << SID_W,
    localparam int PTR_W   = $clog2(HIST_MAX),
    localparam int LEN_W   = $clog2(HIST_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rq_valid,
    input  logic [SID_W-1:0] rq_sid,
    input  logic             hl_we,
    input  logic [LEN_W-1:0] hl_din,
    output logic             pr_valid,
    output logic [SID_W-1:0] pr_sid
);

    logic [LEN_W-1:0] hl_q;
    logic [LEN_W-1:0] hl_clamped;
    logic [SID_W-1:0] log_mem [HIST_MAX];
    logic [PTR_W-1:0] wptr;
    logic [LEN_W-1:0] seen;
    logic [NUM_SID-1:0] tbl_v;
    logic [SID_W-1:0]   tbl_s [NUM_SID];

    logic [PTR_W-1:0] old_idx;
    logic [SID_W-1:0] old_sid;
    logic             train;

    always_comb begin
        if (hl_din == '0)                       hl_clamped = LEN_W'(1);
        else if (hl_din > LEN_W'(HIST_MAX))     hl_clamped = LEN_W'(HIST_MAX);
        else                                    hl_clamped = hl_din;
    end

    // A distance equal to HIST_MAX wraps onto wptr, the oldest slot.
    assign old_idx  = wptr - hl_q[PTR_W-1:0];
    assign old_sid  = log_mem[old_idx];
    assign train    = rq_valid && (seen >= hl_q);
    assign pr_valid = tbl_v[rq_sid];
    assign pr_sid   = tbl_s[rq_sid];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hl_q  <= LEN_W'(HIST_DEF);
            wptr  <= '0;
            seen  <= '0;
            tbl_v <= '0;
        end else begin
            if (hl_we) hl_q <= hl_clamped;
            if (rq_valid) begin
                wptr <= wptr + 1'b1;
                if (seen != LEN_W'(HIST_MAX)) seen <= seen + 1'b1;
            end
            if (train) tbl_v[old_sid] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rq_valid) log_mem[wptr] <= rq_sid;
        if (train)    tbl_s[old_sid] <= rq_sid;
    end

endmodule

// File: rtl/xtp_issue.sv
// Prefetch issue machine with per-tenant outstanding tracking.
module xtp_issue
    import xtp_pkg::*;
#(
    parameter int SID_W    = 4,
    localparam int NUM_SID = 1 << SID_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig,
    input  logic [SID_W-1:0] trig_sid,
    input  logic             rel,
    input  logic [SID_W-1:0] rel_sid,
    input  logic             pf_ready,
    output logic             pf_valid,
    output logic [SID_W-1:0] pf_sid
);

    pf_state_e        state_q;
    pf_state_e        state_d;
    logic [SID_W-1:0] sid_q;
    logic [NUM_SID-1:0] busy_q;
    logic             accept;

    assign accept = (state_q == PF_IDLE) && trig && !busy_q[trig_sid];

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PF_IDLE:  if (accept)   state_d = PF_ISSUE;
            PF_ISSUE: if (pf_ready) state_d = PF_IDLE;
            default:                state_d = PF_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PF_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sid_q  <= '0;
            busy_q <= '0;
        end else begin
            if (rel)    busy_q[rel_sid]  <= 1'b0;
            if (accept) begin
                busy_q[trig_sid] <= 1'b1;
                sid_q            <= trig_sid;
            end
        end
    end

    always_comb begin
        pf_valid = (state_q == PF_ISSUE);
        pf_sid   = sid_q;
    end

endmodule

// File: rtl/xtenant_pf_unit.sv
module xtenant_pf_unit #(
    parameter int SID_W    = 4,
    parameter int PAGE_W   = 20,
    parameter int PHYS_W   = 24,
    parameter int ENTRIES  = 8,
    parameter int HIST_MAX = 64,
    parameter int HIST_DEF = 48,
    localparam int LEN_W   = $clog2(HIST_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [SID_W-1:0]  req_sid,
    input  logic [PAGE_W-1:0] req_page,
    input  logic              hist_len_we,
    input  logic [LEN_W-1:0]  hist_len_din,
    input  logic              fill_valid,
    input  logic [SID_W-1:0]  fill_sid,
    input  logic [PAGE_W-1:0] fill_page,
    input  logic [PHYS_W-1:0] fill_phys,
    input  logic              fill_last,
    output logic              hit_valid,
    output logic [PHYS_W-1:0] hit_phys,
    output logic              miss,
    output logic              pf_req_valid,
    output logic [SID_W-1:0]  pf_req_sid,
    input  logic              pf_req_ready
);

    logic              lk_hit;
    logic [PHYS_W-1:0] lk_phys;
    logic              pr_valid;
    logic [SID_W-1:0]  pr_sid;
    logic              trig;

    xtp_pbuf #(
        .SID_W   (SID_W),
        .PAGE_W  (PAGE_W),
        .PHYS_W  (PHYS_W),
        .ENTRIES (ENTRIES)
    ) u_pbuf (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_sid   (req_sid),
        .lk_page  (req_page),
        .lk_hit   (lk_hit),
        .lk_phys  (lk_phys),
        .fl_valid (fill_valid),
        .fl_sid   (fill_sid),
        .fl_page  (fill_page),
        .fl_phys  (fill_phys)
    );

    xtp_predictor #(
        .SID_W    (SID_W),
        .HIST_MAX (HIST_MAX),
        .HIST_DEF (HIST_DEF)
    ) u_pred (
        .clk      (clk),
        .rst_n    (rst_n),
        .rq_valid (req_valid),
        .rq_sid   (req_sid),
        .hl_we    (hist_len_we),
        .hl_din   (hist_len_din),
        .pr_valid (pr_valid),
        .pr_sid   (pr_sid)
    );

    assign trig = req_valid && !lk_hit && pr_valid;

    xtp_issue #(
        .SID_W (SID_W)
    ) u_issue (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig     (trig),
        .trig_sid (pr_sid),
        .rel      (fill_valid && fill_last),
        .rel_sid  (fill_sid),
        .pf_ready (pf_req_ready),
        .pf_valid (pf_req_valid),
        .pf_sid   (pf_req_sid)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_valid <= 1'b0;
            miss      <= 1'b0;
            hit_phys  <= '0;
        end else begin
            hit_valid <= req_valid && lk_hit;
            miss      <= req_valid && !lk_hit;
            hit_phys  <= lk_hit ? lk_phys : '0;
        end
    end

endmodule

// File: rtl/xtp_checks.sv
module xtp_checks #(
    parameter int SID_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             hit_valid,
    input logic             miss,
    input logic             pf_req_valid,
    input logic [SID_W-1:0] pf_req_sid,
    input logic             pf_req_ready
);

    AST_HIT_MISS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit_valid && miss)) else $error("hit and miss together"); // R3

    AST_RESULT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_valid || miss) |-> $past(req_valid)) else $error("result without request"); // R2

    AST_PF_ONLY_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pf_req_valid) |-> miss) else $error("prefetch without miss"); // R5

    AST_NO_PF_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        hit_valid |-> !$rose(pf_req_valid)) else $error("prefetch on hit"); // R4

    AST_PF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_req_valid && !pf_req_ready) |=> (pf_req_valid && $stable(pf_req_sid))) else $error("prefetch dropped"); // R5

    AST_PF_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_req_valid && pf_req_ready) |=> !pf_req_valid) else $error("back-to-back prefetch"); // R9

endmodule

bind xtenant_pf_unit xtp_checks #(.SID_W(SID_W)) u_xtp_checks (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .hit_valid    (hit_valid),
    .miss         (miss),
    .pf_req_valid (pf_req_valid),
    .pf_req_sid   (pf_req_sid),
    .pf_req_ready (pf_req_ready)
);

// File: tb/xtenant_pf_unit_bench.sv
module xtenant_pf_unit_bench;

    localparam int CLK_PERIOD = 10;
    localparam int SID_W  = 4;
    localparam int PAGE_W = 20;
    localparam int PHYS_W = 24;
    localparam int ENT    = 8;
    localparam int HMAX   = 64;
    localparam int LEN_W  = 7;
    localparam int NSID   = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [SID_W-1:0]  req_sid = '0;
    logic [PAGE_W-1:0] req_page = '0;
    logic              hist_len_we = 1'b0;
    logic [LEN_W-1:0]  hist_len_din = '0;
    logic              fill_valid = 1'b0;
    logic [SID_W-1:0]  fill_sid = '0;
    logic [PAGE_W-1:0] fill_page = '0;
    logic [PHYS_W-1:0] fill_phys = '0;
    logic              fill_last = 1'b0;
    logic              hit_valid;
    logic [PHYS_W-1:0] hit_phys;
    logic              miss;
    logic              pf_req_valid;
    logic [SID_W-1:0]  pf_req_sid;
    logic              pf_req_ready = 1'b1;

    always #(CLK_PERIOD / 2) clk = ~clk;

    xtenant_pf_unit u_xtenant_pf_unit (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_sid      (req_sid),
        .req_page     (req_page),
        .hist_len_we  (hist_len_we),
        .hist_len_din (hist_len_din),
        .fill_valid   (fill_valid),
        .fill_sid     (fill_sid),
        .fill_page    (fill_page),
        .fill_phys    (fill_phys),
        .fill_last    (fill_last),
        .hit_valid    (hit_valid),
        .hit_phys     (hit_phys),
        .miss         (miss),
        .pf_req_valid (pf_req_valid),
        .pf_req_sid   (pf_req_sid),
        .pf_req_ready (pf_req_ready)
    );

    int errors = 0;
    int checks = 0;
    string phase = "R1";

    // Bench model
    bit m_v [ENT];
    int m_sid [ENT];
    int m_pg [ENT];
    int m_ph [ENT];
    int m_rr;
    int m_log [HMAX];
    int m_wp, m_cnt, m_len;
    bit m_tv [NSID];
    int m_ts [NSID];
    bit m_busy [NSID];
    bit m_issuing;
    int m_isid;
    logic [31:0] seed = 32'h1234_5678;

    function automatic int rnd();
        seed = seed * 32'd1103515245 + 32'd12345;
        return int'(seed[30:16]);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < ENT; i++) m_v[i] = 1'b0;
        for (int i = 0; i < NSID; i++) begin
            m_tv[i] = 1'b0; m_busy[i] = 1'b0; m_ts[i] = 0;
        end
        m_rr = 0; m_wp = 0; m_cnt = 0; m_len = 48;
        m_issuing = 1'b0; m_isid = 0;
    endtask

    task automatic do_req(input int s, input int p);
        int hit_i;
        int eph;
        bit epf;
        int epsid;
        int old;
        bit exp_pv;
        int exp_ps;
        hit_i = -1;
        eph = 0;
        for (int e = 0; e < ENT; e++)
            if (m_v[e] && m_sid[e] == s && m_pg[e] == p) begin hit_i = e; eph = m_ph[e]; end
        epsid = m_ts[s];
        epf = (hit_i < 0) && m_tv[s] && !m_busy[epsid] && !m_issuing;
        exp_pv = epf || m_issuing;
        exp_ps = epf ? epsid : m_isid;
        if (m_cnt >= m_len) begin
            old = m_log[(m_wp - m_len) & (HMAX - 1)];
            m_tv[old] = 1'b1;
            m_ts[old] = s;
        end
        m_log[m_wp] = s;
        m_wp = (m_wp + 1) & (HMAX - 1);
        if (m_cnt < HMAX) m_cnt++;
        if (epf) begin
            m_busy[epsid] = 1'b1;
            m_isid = epsid;
            if (!pf_req_ready) m_issuing = 1'b1;
        end
        req_valid = 1'b1; req_sid = SID_W'(s); req_page = PAGE_W'(p);
        @(negedge clk);
        req_valid = 1'b0;
        chk({phase, " R2 hit_valid"}, int'(hit_valid), int'(hit_i >= 0));
        chk({phase, " R3 miss"}, int'(miss), int'(hit_i < 0));
        if (hit_i >= 0) begin
            chk({phase, " R2 hit_phys"}, int'(hit_phys), eph);
            chk({phase, " R4 pf on hit"}, int'(pf_req_valid), int'(m_issuing));
        end else begin
            chk({phase, " R5 R9 pf_req_valid"}, int'(pf_req_valid), int'(exp_pv));
        end
        if (exp_pv) chk({phase, " R5 pf_req_sid"}, int'(pf_req_sid), exp_ps);
        @(negedge clk);
        chk({phase, " R3 idle no result"}, int'(hit_valid || miss), 0);
    endtask

    task automatic do_fill(input int s, input int p, input int ph, input bit last);
        int slot;
        slot = -1;
        for (int e = 0; e < ENT; e++)
            if (slot < 0 && m_v[e] && m_sid[e] == s && m_pg[e] == p) slot = e;
        if (slot < 0)
            for (int e = 0; e < ENT; e++)
                if (slot < 0 && !m_v[e]) slot = e;
        if (slot < 0) begin
            slot = m_rr;
            m_rr = (m_rr + 1) % ENT;
        end
        m_v[slot] = 1'b1; m_sid[slot] = s; m_pg[slot] = p; m_ph[slot] = ph;
        if (last) m_busy[s] = 1'b0;
        fill_valid = 1'b1; fill_sid = SID_W'(s); fill_page = PAGE_W'(p);
        fill_phys = PHYS_W'(ph); fill_last = last;
        @(negedge clk);
        fill_valid = 1'b0; fill_last = 1'b0;
    endtask

    task automatic set_len(input int v);
        m_len = (v == 0) ? 1 : ((v > HMAX) ? HMAX : v);
        hist_len_we = 1'b1; hist_len_din = LEN_W'(v);
        @(negedge clk);
        hist_len_we = 1'b0;
    endtask

    task automatic random_run(input int iters, input int salt);
        for (int it = 0; it < iters; it++) begin
            int r;
            int bs;
            r = rnd();
            bs = -1;
            for (int i = 0; i < NSID; i++) if (bs < 0 && m_busy[i]) bs = i;
            if (bs >= 0 && (r % 4) == 0) begin
                int p1;
                p1 = rnd() % 4;
                do_fill(bs, p1, (bs << 12) | (p1 << 4) | ((it + salt) & 15), 1'b0);
                p1 = rnd() % 4;
                do_fill(bs, p1, (bs << 12) | (p1 << 4) | ((it + salt + 7) & 15), 1'b1);
            end else begin
                do_req(rnd() % 6, rnd() % 4);
            end
        end
    endtask

    initial begin
        int rel_cnt;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports
        chk("R1 hit_valid", int'(hit_valid), 0);
        chk("R1 miss", int'(miss), 0);
        chk("R1 pf_req_valid", int'(pf_req_valid), 0);
        phase = "R1";
        do_req(3, 1);
        do_req(4, 1);

        // R7/R6: default length 48, then a short history and the clamp
        phase = "R6";
        random_run(120, 0);
        phase = "R7";
        set_len(3);
        random_run(120, 3);
        set_len(0);
        random_run(80, 5);
        set_len(100);
        random_run(160, 9);

        // R5 hold, R9 suppression, R10 release (distance 1)
        phase = "R9";
        for (int i = 0; i < NSID; i++) begin
            if (m_busy[i]) begin
                do_fill(i, 9, 16'h0ff0, 1'b1);
            end
        end
        set_len(1);
        do_req(1, 7);
        do_req(2, 7);
        pf_req_ready = 1'b0;
        phase = "R5";
        do_req(1, 7);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R5 held valid", int'(pf_req_valid), int'(m_issuing));
            chk("R5 held sid", int'(pf_req_sid), m_isid);
        end
        phase = "R9";
        do_req(2, 7);
        pf_req_ready = 1'b1;
        @(negedge clk);
        m_issuing = 1'b0;
        chk("R5 accepted", int'(pf_req_valid), 0);
        do_req(1, 7);
        phase = "R10";
        rel_cnt = 0;
        for (int i = 0; i < NSID; i++) if (m_busy[i]) rel_cnt++;
        do_fill(2, 7, 24'h2070, 1'b1);
        do_req(2, 8);
        do_req(1, 8);
        chk("R10 released sid reissued", int'(rel_cnt > 0 && m_busy[2]), 1);

        // R8: placement and round-robin victim sweep with an unused tenant
        phase = "R8";
        set_len(64);
        for (int p = 0; p < 11; p++) do_fill(15, p + 20, 24'hF0000 | p, 1'b0);
        do_fill(15, 25, 24'hABCDE, 1'b0);
        for (int p = 0; p < 11; p++) do_req(15, p + 20);

        phase = "R6";
        random_run(150, 11);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule